// File: doc/BRIEF.md
# I2C Bus Recovery Clock Pulser

This block frees an I2C bus that a slave has left stuck part-way through a transfer, for example after the master was reset mid-byte. When triggered it takes the pins away from the normal controller, releases both lines and samples them. If SCL and SDA are already high, it reports success at once. Otherwise it clocks SCL with a programmable number of open-drain pulses, enough to walk the slave through the rest of its packet and the acknowledge slot. It then waits, within a bounded time, for both lines to read high.

The pulse count is 9 by default. When a nonzero maximum transaction length of N bytes is given, it becomes N*8+1. Every timing interval counts a one-microsecond tick input, so the block runs from any system clock. SDA is only ever sampled, never driven. Both sampled lines pass through a synchronizer before the state machine uses them. At the end the block hands the pins back, raises a one-cycle done strobe, and flags an error if the bus did not return to idle.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, own_bus_o, scl_drive_o, done_o and err_o are all 0.
- R2: A start_i pulse while own_bus_o is 0 sets own_bus_o in the next cycle. SCL is released while the lines are first sampled. scl_drive_o is only 1 while own_bus_o is 1.
- R3: If SCL and SDA both read high after the SYNC_STAGES-cycle synchronizer settles, done_o rises with err_o=0 and no SCL pulse is made. done_o is seen 3 clock edges after the edge that samples start_i, with SYNC_STAGES=2.
- R4: When max_bytes_i is 0 and the bus is not idle at the check, exactly 9 SCL pulses are generated. max_bytes_i is sampled in the check cycle.
- R5: When max_bytes_i is N, nonzero, and the bus is not idle at the check, exactly N*8+1 SCL pulses are generated.
- R6: Each pulse holds scl_drive_o at 1 for HALF_US ticks, then releases it for HALF_US ticks. Without us_tick_i pulses, scl_drive_o does not change.
- R7: After the last released half-period, the block samples both lines every cycle. On the first cycle both read high, it ends with err_o=0, one clock edge after the wait begins.
- R8: If both lines do not read high within TIMEOUT_US ticks of the wait, the block ends with err_o=1.
- R9: done_o is a one-cycle pulse. err_o is 1 only together with done_o. own_bus_o falls in the same cycle done_o rises, and not otherwise.
- R10: start_i is ignored while own_bus_o is 1. It causes no restart, no extra pulses and no second done_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Recovery trigger, one-cycle pulse |
| max_bytes_i | input | BYTE_W | Slave packet size in bytes; 0 selects the default of 9 pulses |
| scl_i | input | 1 | Sampled SCL pin level |
| sda_i | input | 1 | Sampled SDA pin level |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| scl_drive_o | output | 1 | 1 pulls SCL low (open-drain enable) |
| own_bus_o | output | 1 | 1 while the pins are muxed to this block |
| done_o | output | 1 | One-cycle end-of-recovery strobe |
| err_o | output | 1 | Bus still busy after timeout, valid with done_o |

## Verification
The bench runs with one tick per clock, so every interval is an exact cycle count. For an idle bus, done_o is due on the third edge after the start edge. That is two synchronizer stages plus the decision cycle. After pulsing, done_o is due HALF_US+1 edges after the last fall of scl_drive_o on success, or HALF_US+TIMEOUT_US edges on timeout. Each low phase lasts exactly HALF_US cycles. The bench counts negative edges from those reference events and compares at the precise cycle where each result must appear, not with a tolerance window.

// File: rtl/unstick_pkg.sv
// Shared definitions for the I2C bus recovery pulser.
// Assumes nothing beyond a single clock domain for its users.
package unstick_pkg;

    // Recovery sequencer states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_CHECK  = 3'd2,
        ST_LOW    = 3'd3,
        ST_HIGH   = 3'd4,
        ST_WAIT   = 3'd5
    } unstick_state_e;

    // Clocks per byte on the bus and the extra acknowledge clock
    localparam int BITS_PER_BYTE = 8;
    localparam int ACK_CLOCKS    = 1;

endpackage

// File: rtl/unstick_sync.sv
// Multi-stage synchronizer for asynchronous pin samples.
// Assumes the inputs idle high (released open-drain lines), so the stages reset to 1.
module unstick_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw pin levels
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '1;
                    else        stage_q[g] <= d_i;
                end
            end else begin : g_next
                // Later stages shift the value along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '1;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/unstick_timer.sv
// Down-counter of microsecond ticks. A load starts an interval of load_val_i ticks.
// expire_o pulses on the tick that completes it. Assumes load_val_i >= 1.
module unstick_timer #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          tick_i,
    output logic          expire_o
);

    logic [CW-1:0] cnt_q;

    // Remaining ticks; a load takes priority over counting
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (load_i)                    cnt_q <= load_val_i;
        else if (tick_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = tick_i && (cnt_q == CW'(1));

endmodule

// File: rtl/unstick_pulse_count.sv
// Holds the number of SCL pulses still owed. On load it computes the total from
// the packet size (9 for 0, else N*8+1); last_o flags the final pulse.
module unstick_pulse_count #(
    parameter int BYTE_W = 4,
    parameter int CW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] max_bytes_i,
    input  logic              step_i,
    output logic              last_o
);
    import unstick_pkg::*;

    localparam int DEFAULT_PULSES = BITS_PER_BYTE + ACK_CLOCKS;

    logic [CW-1:0] total;
    logic [CW-1:0] left_q;

    // Pulse total for the configured packet size
    always_comb begin
        if (max_bytes_i == '0) total = CW'(DEFAULT_PULSES);
        else                   total = CW'(max_bytes_i) * CW'(BITS_PER_BYTE) + CW'(ACK_CLOCKS);
    end

    // Pulses remaining in the current recovery
    always_ff @(posedge clk) begin
        if (!rst_n)                        left_q <= '0;
        else if (load_i)                   left_q <= total;
        else if (step_i && left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign last_o = (left_q == CW'(1));

endmodule

// File: rtl/i2c_bus_unstick.sv
// I2C bus recovery pulser. On start_i it takes the pins, releases both lines and
// checks for idle. If the bus is held, it clocks SCL a set number of times, then
// waits a bounded time for both lines high. Assumes scl_i/sda_i are the real pin
// levels (open-drain wired-AND) and us_tick_i is a one-cycle pulse per microsecond.
module i2c_bus_unstick #(
    parameter int BYTE_W      = 4,
    parameter int HALF_US     = 50,
    parameter int TIMEOUT_US  = 200000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] max_bytes_i,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              us_tick_i,
    output logic              scl_drive_o,
    output logic              own_bus_o,
    output logic              done_o,
    output logic              err_o
);
    import unstick_pkg::*;

    localparam int TMAX       = (TIMEOUT_US > HALF_US) ? TIMEOUT_US : HALF_US;
    localparam int TMR_W      = $clog2(TMAX + 1);
    localparam int MAX_PULSES = ((1 << BYTE_W) - 1) * BITS_PER_BYTE + ACK_CLOCKS;
    localparam int PCNT_W     = $clog2(MAX_PULSES + 1);
    localparam int SET_W      = $clog2(SYNC_STAGES + 1);

    unstick_state_e state_q, state_d;
    logic [SET_W-1:0] settle_q;
    logic [1:0]       pins_s;
    logic             bus_idle;
    logic             tmr_load, tmr_expire;
    logic [TMR_W-1:0] tmr_val;
    logic             pc_load, pc_step, pc_last;
    logic             fin, fin_err;
    logic             done_q, err_q;

    unstick_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (pins_s)
    );

    assign bus_idle = pins_s[1] & pins_s[0];

    unstick_timer #(.CW(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .tick_i     (us_tick_i),
        .expire_o   (tmr_expire)
    );

    unstick_pulse_count #(.BYTE_W(BYTE_W), .CW(PCNT_W)) u_pcount (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (pc_load),
        .max_bytes_i (max_bytes_i),
        .step_i      (pc_step),
        .last_o      (pc_last)
    );

    // Next-state and control decode for the recovery sequence
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(HALF_US);
        pc_load  = 1'b0;
        pc_step  = 1'b0;
        fin      = 1'b0;
        fin_err  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (settle_q <= SET_W'(1)) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (bus_idle) begin
                    fin     = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    pc_load  = 1'b1;
                    tmr_load = 1'b1;
                    state_d  = ST_LOW;
                end
            end
            ST_LOW: begin
                if (tmr_expire) begin
                    tmr_load = 1'b1;
                    state_d  = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tmr_expire) begin
                    pc_step  = 1'b1;
                    tmr_load = 1'b1;
                    if (pc_last) begin
                        tmr_val = TMR_W'(TIMEOUT_US);
                        state_d = ST_WAIT;
                    end else begin
                        state_d = ST_LOW;
                    end
                end
            end
            ST_WAIT: begin
                if (bus_idle) begin
                    fin     = 1'b1;
                    state_d = ST_IDLE;
                end else if (tmr_expire) begin
                    fin     = 1'b1;
                    fin_err = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Cycles left for the synchronizer to reflect released lines
    always_ff @(posedge clk) begin
        if (!rst_n)                                  settle_q <= '0;
        else if (state_q == ST_IDLE && start_i)      settle_q <= SET_W'(SYNC_STAGES);
        else if (state_q == ST_SETTLE && settle_q != '0) settle_q <= settle_q - 1'b1;
    end

    // Registered completion strobe and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= fin;
            err_q  <= fin_err;
        end
    end

    assign scl_drive_o = (state_q == ST_LOW);
    assign own_bus_o   = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign err_o       = err_q;

endmodule

// File: rtl/unstick_checker.sv
// Protocol checker for i2c_bus_unstick, bound to every instance.
// Assumes only the top-level ports; it keeps its own tick counter for widths.
module unstick_checker #(
    parameter int HALF_US = 50
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic us_tick_i,
    input logic scl_drive_o,
    input logic own_bus_o,
    input logic done_o,
    input logic err_o
);

    int low_ticks;

    // Ticks seen while SCL is pulled low
    always_ff @(posedge clk) begin
        if (!rst_n)            low_ticks <= 0;
        else if (!scl_drive_o) low_ticks <= 0;
        else if (us_tick_i)    low_ticks <= low_ticks + 1;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !own_bus_o && !scl_drive_o && !done_o && !err_o);

    a_r2_drive_needs_own: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_o |-> own_bus_o);

    a_r2_take_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_bus_o && start_i) |=> own_bus_o);

    a_r6_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_o) |-> (low_ticks == HALF_US));

    a_r6_fall_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_o) |-> $past(us_tick_i));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    a_r9_release_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!own_bus_o && $past(own_bus_o)));

    a_r9_release_means_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own_bus_o) |-> done_o);

    a_r10_no_spurious_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_bus_o) |-> $past(start_i));

endmodule

bind i2c_bus_unstick unstick_checker #(.HALF_US(HALF_US)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .us_tick_i   (us_tick_i),
    .scl_drive_o (scl_drive_o),
    .own_bus_o   (own_bus_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/i2c_bus_unstick_tb.sv
module i2c_bus_unstick_tb;

    localparam int BW   = 3;
    localparam int HALF = 4;
    localparam int TOUT = 60;
    localparam int NVEC = 8;

    // {max_bytes[3:0], sda_release_after_falls[7:0], scl_stuck[3:0]}; release 0 = SDA free
    localparam logic [15:0] VEC [NVEC] = '{
        {4'd0, 8'd0,   4'd0},
        {4'd0, 8'd3,   4'd0},
        {4'd2, 8'd5,   4'd0},
        {4'd7, 8'd1,   4'd0},
        {4'd1, 8'd255, 4'd0},
        {4'd0, 8'd0,   4'd1},
        {4'd3, 8'd9,   4'd0},
        {4'd0, 8'd12,  4'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [BW-1:0] max_bytes = '0;
    logic tick_en = 1'b1;
    logic scl_drive, own_bus, done, err;
    logic scl_line, sda_line;

    int cfg_rel = 0;
    bit cfg_stk = 1'b0;
    bit clr = 1'b0;
    int falls;
    logic prv_drive;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    // Slave model: SDA held low until a number of SCL pulses have passed
    always_ff @(posedge clk) begin
        if (clr) begin
            falls     <= 0;
            prv_drive <= 1'b0;
        end else begin
            prv_drive <= scl_drive;
            if (prv_drive && !scl_drive) falls <= falls + 1;
        end
    end

    assign scl_line = !scl_drive && !cfg_stk;
    assign sda_line = !(cfg_rel != 0 && falls < cfg_rel);

    i2c_bus_unstick #(.BYTE_W(BW), .HALF_US(HALF), .TIMEOUT_US(TOUT), .SYNC_STAGES(2)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .max_bytes_i (max_bytes),
        .scl_i       (scl_line),
        .sda_i       (sda_line),
        .us_tick_i   (tick_en),
        .scl_drive_o (scl_drive),
        .own_bus_o   (own_bus),
        .done_o      (done),
        .err_o       (err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Run one recovery; all observations taken at negative edges
    task automatic run_case(input int mb, input int rel, input bit stk, input bit poke,
                            output int pulses, output int err_v, output int since_fall,
                            output int start_lat, output int low_w, output int got,
                            output int own_at_done);
        int k, last_hi, cur;
        bit prev_d, d;
        @(negedge clk);
        clr = 1'b1; cfg_rel = rel; cfg_stk = stk; max_bytes = BW'(mb);
        @(negedge clk);
        clr = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1;
        k = 0; last_hi = 0; cur = 0; prev_d = 1'b0;
        pulses = 0; low_w = 0; got = 0; err_v = -1; since_fall = -1; start_lat = -1; own_at_done = -1;
        while (k < 3000) begin
            @(negedge clk);
            k++;
            if (k == 1) start = 1'b0;
            if (poke && k == 30) start = 1'b1;
            if (poke && k == 31) start = 1'b0;
            d = scl_drive;
            if (d && !prev_d) pulses++;
            if (d) begin
                cur++;
                last_hi = k;
            end
            if (!d && prev_d && low_w == 0) low_w = cur;
            if (!d) cur = 0;
            prev_d = d;
            if (done) begin
                got = 1;
                err_v = int'(err);
                start_lat = k;
                since_fall = k - last_hi;
                own_at_done = int'(own_bus);
                break;
            end
        end
    endtask

    initial begin
        int p, e, sf, sl, lw, g, od, exp_p, exp_e, mb, rel, held, extra;
        bit stk;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 own_bus", int'(own_bus), 0);
        chk("R1 scl_drive", int'(scl_drive), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            mb  = int'(VEC[i][15:12]);
            rel = int'(VEC[i][11:4]);
            stk = VEC[i][0];
            exp_p = (rel == 0 && !stk) ? 0 : ((mb == 0) ? 9 : mb * 8 + 1);
            exp_e = (exp_p != 0 && (stk || rel > exp_p)) ? 1 : 0;
            run_case(mb, rel, stk, 1'b0, p, e, sf, sl, lw, g, od);
            chk($sformatf("R9 done seen v%0d", i), g, 1);
            chk($sformatf("R9 own released at done v%0d", i), od, 0);
            if (exp_p == 0) begin
                chk($sformatf("R3 no pulses v%0d", i), p, 0);
                chk($sformatf("R3 latency v%0d", i), sl, 4);
                chk($sformatf("R3 err v%0d", i), e, 0);
            end else begin
                chk($sformatf("%s pulse count v%0d", (mb == 0) ? "R4" : "R5", i), p, exp_p);
                chk($sformatf("R6 low width v%0d", i), lw, HALF);
                if (exp_e == 1) begin
                    chk($sformatf("R8 err v%0d", i), e, 1);
                    chk($sformatf("R8 timeout latency v%0d", i), sf, HALF + TOUT + 1);
                end else begin
                    chk($sformatf("R7 err v%0d", i), e, 0);
                    chk($sformatf("R7 idle latency v%0d", i), sf, HALF + 2);
                end
            end
        end

        // R2: ownership one cycle after trigger and SCL released while sampling
        @(negedge clk);
        clr = 1'b1; cfg_rel = 0; cfg_stk = 1'b0;
        @(negedge clk);
        clr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 own_bus after trigger", int'(own_bus), 1);
        chk("R2 scl released during check", int'(scl_drive), 0);
        repeat (6) @(negedge clk);

        // R6: no ticks, no progress
        tick_en = 1'b0;
        @(negedge clk);
        clr = 1'b1; cfg_rel = 3; cfg_stk = 1'b0; max_bytes = '0;
        @(negedge clk);
        clr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        held = 0;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            if (scl_drive) held++;
        end
        chk("R6 scl held without ticks", held, 40);
        tick_en = 1'b1;
        g = 0;
        for (int j = 0; j < 2000 && g == 0; j++) begin
            @(negedge clk);
            if (done) begin
                g = 1;
                e = int'(err);
            end
        end
        chk("R6 completes once ticks resume", g, 1);
        chk("R6 success once ticks resume", e, 0);

        // R10: trigger mid-recovery ignored
        run_case(0, 3, 1'b0, 1'b1, p, e, sf, sl, lw, g, od);
        chk("R10 pulse count unchanged", p, 9);
        chk("R10 single result ok", e, 0);
        extra = 0;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            if (own_bus || done || scl_drive) extra++;
        end
        chk("R10 no restart after done", extra, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule